// File: doc/BRIEF.md
# Quad Element Swizzle Unit

This unit rearranges vector elements four at a time. A vector of VL groups is taken from a register file, one element per entry. For group g, the four source elements sit at entries src+4g .. src+4g+3. They are read into a small lane buffer, and then four destination entries dst+4g .. dst+4g+3 are written. Each destination lane picks one of the four buffered lanes. An 8-bit immediate holds four 2-bit lane selectors that make this choice.

The unit has a single read port and a single write port. Read data returns one cycle after the read is issued, which matches a synchronous block RAM. A group is fully buffered before any of its writes, so the source and destination ranges may be the same. Software pulses `start` with the vector length, both base addresses and the immediate. The unit raises `busy` and pulses `done` when every group has been written back. Addresses wrap modulo the 128-entry register file.

Top module: `quad_swizzle`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `rf_re` and `rf_we` are all low.
- R2: Reads are issued at `src_base`, `src_base+1`, … in strictly increasing order, one per read cycle. Group g lane j is read from `src_base+4g+j`.
- R3: Per group there are exactly four consecutive read cycles, then one idle cycle, then four consecutive write cycles. No write of a group happens before all four of its reads, and `rf_re` and `rf_we` are never high together.
- R4: Destination entry `dst_base+4g+j` receives source lane s of the same group, where s = imm[2j+1:2j] (bits 1:0 select for lane 0, bits 7:6 for lane 3).
- R5: Immediate 0xE4 copies each group unchanged. Immediate 0x1B reverses the lane order of each group.
- R6: With `src_base == dst_base` (in place), the result equals the permutation of the original contents.
- R7: `start` with `vl == 0` gives a `done` pulse in the cycle after the start edge, with no reads and no writes.
- R8: `vl`, both bases and the immediate are latched on an accepted `start`. A `start` while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse seen 9*vl cycles after the start edge. The next cycle `busy` is low.
- R10: Source and destination addresses wrap modulo 128 (ADDR_W = 7).
- R11: A run with length vl makes exactly 4*vl reads and 4*vl writes. `rf_rdata` is sampled one cycle after the read that requested it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| vl | input | VL_W | Number of four-element groups |
| src_base | input | ADDR_W | First source element |
| dst_base | input | ADDR_W | First destination element |
| imm | input | 8 | Four 2-bit lane selectors, lane 0 in bits 1:0 |
| busy | output | 1 | High from accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| rf_re | output | 1 | Register file read enable |
| rf_raddr | output | ADDR_W | Read address |
| rf_rdata | input | DATA_W | Read data, valid one cycle after rf_re |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | ADDR_W | Write address |
| rf_wdata | output | DATA_W | Write data |

## Verification
The hardest case to reach is a source range that overlaps a destination range that is still being written. An earlier group's writes then change what a later group reads. The stimulus covers this with in-place runs and a run whose destination is offset by two entries from its source. The expected image comes from a group-by-group model that updates its copy of memory as it goes. Ranges that cross entry 127 and a restart attempt in the middle of a run are also driven. In each case the whole 128-entry memory is compared afterwards.

// File: rtl/qswz_pkg.sv
package qswz_pkg;
  localparam int LANES  = 4;
  localparam int SEL_W  = 2;
  localparam int IMM_W  = LANES * SEL_W;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } qswz_state_t;
endpackage

// File: rtl/qswz_ctrl.sv
module qswz_ctrl
  import qswz_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int VL_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_lane,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANE_W-1:0] wr_lane
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  qswz_state_t       state;
  logic [LANE_W-1:0] lane;
  logic [VL_W-1:0]   grp;
  logic [VL_W-1:0]   vl_q;
  logic [ADDR_W-1:0] rptr;
  logic [ADDR_W-1:0] wptr;

  assign accept = start && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      lane  <= '0;
      grp   <= '0;
      vl_q  <= '0;
      rptr  <= '0;
      wptr  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          vl_q  <= vl;
          rptr  <= src_base;
          wptr  <= dst_base;
          lane  <= '0;
          grp   <= '0;
          state <= (vl == '0) ? ST_DONE : ST_READ;
        end
        ST_READ: begin
          rptr <= rptr + 1'b1;
          lane <= lane + 1'b1;
          if (lane == LAST_LANE) state <= ST_WAIT;
        end
        ST_WAIT: state <= ST_WRITE;
        ST_WRITE: begin
          wptr <= wptr + 1'b1;
          lane <= lane + 1'b1;
          if (lane == LAST_LANE) begin
            grp   <= grp + 1'b1;
            state <= ((grp + 1'b1) == vl_q) ? ST_DONE : ST_READ;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign rd_en   = (state == ST_READ);
  assign rd_addr = rptr;
  assign rd_lane = lane;
  assign wr_en   = (state == ST_WRITE);
  assign wr_addr = wptr;
  assign wr_lane = lane;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R3
  AST_READ_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_en) |-> !wr_en); // R3
  AST_RADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R2
  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy)); // R9
  AST_ZERO_VL: assert property (@(posedge clk) disable iff (rst)
    (accept && (vl == '0)) |=> done); // R7
  AST_HOLD_ARGS: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(vl_q)); // R8
endmodule

// File: rtl/qswz_lane_buf.sv
module qswz_lane_buf
  import qswz_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [LANE_W-1:0]            rd_lane,
  input  logic [DATA_W-1:0]            rd_data,
  output logic [LANES-1:0][DATA_W-1:0] bank
);
  logic              cap_vld;
  logic [LANE_W-1:0] cap_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld  <= 1'b0;
      cap_lane <= '0;
    end else begin
      cap_vld  <= rd_en;
      cap_lane <= rd_lane;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (cap_vld && (cap_lane == LANE_W'(k))) bank[k] <= rd_data;
    end
  end
endmodule

// File: rtl/qswz_lane_xbar.sv
module qswz_lane_xbar
  import qswz_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [IMM_W-1:0]             imm_in,
  input  logic [LANE_W-1:0]            wr_lane,
  input  logic [LANES-1:0][DATA_W-1:0] bank,
  output logic [DATA_W-1:0]            wdata
);
  logic [IMM_W-1:0]            imm_q;
  logic [LANES-1:0][SEL_W-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst)       imm_q <= '0;
    else if (load) imm_q <= imm_in;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_sel
    assign sel[j] = imm_q[j*SEL_W +: SEL_W];
  end

  assign wdata = bank[sel[wr_lane]];
endmodule

// File: rtl/quad_swizzle.sv
module quad_swizzle
  import qswz_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int VL_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [IMM_W-1:0]  imm,
  output logic              busy,
  output logic              done,
  output logic              rf_re,
  output logic [ADDR_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic                         accept;
  logic [LANE_W-1:0]            rd_lane;
  logic [LANE_W-1:0]            wr_lane;
  logic [LANES-1:0][DATA_W-1:0] bank;

  qswz_ctrl #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .src_base(src_base), .dst_base(dst_base), .accept(accept),
    .busy(busy), .done(done),
    .rd_en(rf_re), .rd_addr(rf_raddr), .rd_lane(rd_lane),
    .wr_en(rf_we), .wr_addr(rf_waddr), .wr_lane(wr_lane)
  );

  qswz_lane_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .rd_en(rf_re), .rd_lane(rd_lane),
    .rd_data(rf_rdata), .bank(bank)
  );

  qswz_lane_xbar #(.DATA_W(DATA_W)) u_xbar (
    .clk(clk), .rst(rst), .load(accept), .imm_in(imm),
    .wr_lane(wr_lane), .bank(bank), .wdata(rf_wdata)
  );
endmodule

// File: tb/quad_swizzle_bench.sv
`timescale 1ns/1ps
module quad_swizzle_bench;
  localparam int DW = 32;
  localparam int AW = 7;
  localparam int VW = 6;
  localparam int DEPTH = 128;
  localparam int NV = 8;
  // {vl[27:22], src[21:15], dst[14:8], imm[7:0]}
  localparam logic [27:0] VEC [NV] = '{
    {6'd2, 7'd0,   7'd64,  8'hE4},  // R5 identity
    {6'd2, 7'd8,   7'd72,  8'h1B},  // R5 reverse
    {6'd3, 7'd16,  7'd80,  8'h00},  // R4 broadcast lane 0
    {6'd1, 7'd20,  7'd90,  8'h9C},  // R4 mixed selectors
    {6'd4, 7'd32,  7'd32,  8'h1B},  // R6 in place
    {6'd2, 7'd124, 7'd100, 8'h4E},  // R10 source wrap
    {6'd2, 7'd40,  7'd126, 8'hB1},  // R10 destination wrap
    {6'd3, 7'd48,  7'd50,  8'h39}   // R6 overlapping ranges
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [VW-1:0] vl = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [7:0] imm = '0;
  logic busy, done, rf_re, rf_we;
  logic [AW-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] model [DEPTH];
  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, grp_reads = 0, r3_viol = 0, addr_viol = 0;
  int exp_ra = 0, exp_wa = 0;
  logic last_wr = 1'b0;

  always #2 clk = ~clk;

  quad_swizzle #(.DATA_W(DW), .ADDR_W(AW), .VL_W(VW)) u_quad_swizzle (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .src_base(src_base), .dst_base(dst_base), .imm(imm),
    .busy(busy), .done(done),
    .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // Register file environment: synchronous read, one cycle latency.
  always @(posedge clk) begin
    if (rf_re) rf_rdata <= mem[rf_raddr];
    if (rf_we) mem[rf_waddr] <= rf_wdata;
  end

  // Port monitor for read/write ordering and address sequence.
  always @(posedge clk) begin
    if (rf_re) begin
      rd_cnt++;
      if (int'(rf_raddr) != exp_ra) addr_viol++;
      exp_ra = (exp_ra + 1) % DEPTH;
      grp_reads = last_wr ? 1 : grp_reads + 1;
      last_wr = 1'b0;
      if (rf_we) r3_viol++;
    end
    if (rf_we) begin
      wr_cnt++;
      if (int'(rf_waddr) != exp_wa) addr_viol++;
      exp_wa = (exp_wa + 1) % DEPTH;
      if (grp_reads != 4) r3_viol++;
      last_wr = 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < DEPTH; a++) begin
      mem[a] = 32'h5A00_0000 ^ (a * 32'h0101_0101) ^ (seed << 20);
      model[a] = mem[a];
    end
  endtask

  task automatic predict(input int n, input int s, input int d, input int im);
    logic [DW-1:0] lb [4];
    for (int g = 0; g < n; g++) begin
      for (int j = 0; j < 4; j++) lb[j] = model[(s + 4*g + j) % DEPTH];
      for (int j = 0; j < 4; j++) model[(d + 4*g + j) % DEPTH] = lb[(im >> (2*j)) & 3];
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) if (mem[a] !== model[a]) bad++;
    check(req, bad, 0);
  endtask

  task automatic launch(input int n, input int s, input int d, input int im);
    @(negedge clk);
    vl = VW'(n); src_base = AW'(s); dst_base = AW'(d); imm = 8'(im);
    rd_cnt = 0; wr_cnt = 0; r3_viol = 0; addr_viol = 0; grp_reads = 0;
    exp_ra = s; exp_wa = d; last_wr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_vec(input logic [27:0] v, input int idx);
    int n, s, d, im, lat;
    n = int'(v[27:22]); s = int'(v[21:15]); d = int'(v[14:8]); im = int'(v[7:0]);
    fill(idx + 1);
    predict(n, s, d, im);
    launch(n, s, d, im);
    wait_done(lat);
    check("R9 latency", lat, 9 * n);
    @(negedge clk);
    check("R9 done pulse/busy", int'(done) + int'(busy), 0);
    check("R11 reads", rd_cnt, 4 * n);
    check("R11 writes", wr_cnt, 4 * n);
    check("R3 order", r3_viol, 0);
    check("R2 R10 addresses", addr_viol, 0);
    compare_mem("R4 R5 R6 R10 contents");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset outputs", int'(busy) + int'(done) + int'(rf_re) + int'(rf_we), 0);

    foreach (VEC[i]) run_vec(VEC[i], i);

    // R7 zero length
    fill(20);
    launch(0, 5, 9, 8'h1B);
    check("R7 done after start", int'(done), 1);
    @(negedge clk);
    check("R7 no access", rd_cnt + wr_cnt, 0);
    compare_mem("R7 memory untouched");

    // R8 start while busy is ignored
    fill(21);
    predict(2, 60, 70, 8'hE4);
    launch(2, 60, 70, 8'hE4);
    @(negedge clk);
    vl = 6'd5; src_base = 7'd3; dst_base = 7'd3; imm = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check("R8 latency unchanged", lat, 9 * 2 - 2);
    @(negedge clk);
    check("R8 writes", wr_cnt, 8);
    compare_mem("R8 contents");

    // R1 reset in mid-run returns to idle
    launch(3, 0, 0, 8'h1B);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", int'(busy) + int'(rf_re) + int'(rf_we), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule